// File: doc/BRIEF.md
# Single-Bit Test and Modify Datapath

This block carries out the four single-bit instructions of a 16/32-bit processor. One bit of a destination operand is examined and then left alone, inverted, forced low or forced high. The bit number arrives as a small operand. It is reduced according to the destination kind: a data register is 32 bits wide, while a memory destination is a single byte. The zero flag of the condition code vector is set to the inverse of the examined bit, taken before any change, and every other flag passes through untouched.

Beside the new operand value, the block reports whether the destination must be written back and how many clock periods the instruction costs. That cost depends on whether the bit number came from a register or from an immediate extension word. The sequencer selects the form through a separate input. Effective-address work, memory cycles and fetch are done elsewhere.

Requests enter through a valid/ready pair. Each accepted request fills an output register stage, which presents it through its own valid/ready pair. That stage holds its contents for as long as the consumer stalls.

Top module: `bitop_unit`

## Requirements
- R1: The operation code `in_op` uses 00 = test (operand unchanged), 01 = invert the bit (XOR with the mask), 10 = force the bit to 0 (AND with the inverted mask), 11 = force the bit to 1 (OR with the mask).
- R2: When `in_is_reg` is 1, the bit number is taken modulo 32 and all 32 bits of `in_operand` are used and returned.
- R3: When `in_is_reg` is 0, the bit number is taken modulo 8, only `in_operand[7:0]` is used, and `out_result[31:8]` is 0.
- R4: `out_ccr[2]` (zero flag) is 1 exactly when the selected bit was 0 before the operation; bits 4, 3, 1 and 0 of `out_ccr` equal those of `in_ccr`.
- R5: `out_wb` is 1 for codes 01, 10 and 11 and 0 for test.
- R6: With `in_imm_form` = 0, `out_cycles` is 4 for test and 8 for the modifying codes, plus 2 for test or force-to-0 on a register destination.
- R7: With `in_imm_form` = 1, `out_cycles` is 8 for test and 12 for the modifying codes, plus 2 for test or force-to-0 on a register destination.
- R8: `in_ready` equals `!out_valid || out_ready`. An accepted request appears on the outputs with `out_valid` = 1 at the next clock edge. While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values.
- R9: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | Operation code |
| in_imm_form | input | 1 | 1 = bit number from immediate word, 0 = from register |
| in_is_reg | input | 1 | 1 = data register destination, 0 = memory byte |
| in_bitnum | input | 6 | Bit number before reduction |
| in_operand | input | 32 | Destination value |
| in_ccr | input | 5 | Current condition codes, zero flag at bit 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | New destination value |
| out_wb | output | 1 | Destination must be written |
| out_ccr | output | 5 | Updated condition codes |
| out_cycles | output | 5 | Instruction cycle cost |

## Verification
The hardest situation to reach is a new request waiting at the input while the output stage is stalled. In that situation the held result must neither change nor be overwritten. The bench lowers `out_ready` on a repeating pattern that is unrelated to the request sequence, so that stalls fall on every kind of result. A second hard case is a bit number from 32 to 63, or from 8 upward on a byte destination. The bench sweeps all 64 bit numbers for every code, destination kind and numbering form, so every wrap path is taken.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int BITNUM_W = 6;
  localparam int CCR_W    = 5;
  localparam int ZF_POS   = 2;
  localparam int CYC_W    = 5;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_FLIP = 2'b01,
    OP_CLR  = 2'b10,
    OP_SET  = 2'b11
  } bitop_e;
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int BITNUM_W = 6
) (
  input  logic [BITNUM_W-1:0] bitnum,
  input  logic                is_reg,
  output logic [DATA_W-1:0]   mask
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] idx;
  logic             unused_hi;

  assign unused_hi = ^bitnum[BITNUM_W-1:IDX_W];

  always_comb begin
    if (is_reg) idx = bitnum[IDX_W-1:0];
    else        idx = {{(IDX_W-BIDX_W){1'b0}}, bitnum[BIDX_W-1:0]};
    mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              is_reg,
  input  bitop_e            op,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] result,
  output logic              wb,
  output logic              bit_zero
);
  logic [DATA_W-1:0] view;

  always_comb begin
    if (is_reg) view = operand;
    else        view = {{(DATA_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
    bit_zero = ((view & mask) == '0);
    wb       = (op != OP_TEST);
    case (op)
      OP_FLIP: result = view ^ mask;
      OP_CLR:  result = view & ~mask;
      OP_SET:  result = view | mask;
      default: result = view;
    endcase
  end
endmodule

// File: rtl/bitop_cycles.sv
module bitop_cycles
  import bitop_pkg::*;
#(
  parameter int CYC_W     = 5,
  parameter int REG_BASE  = 4,
  parameter int IMM_BASE  = 8,
  parameter int MOD_EXTRA = 4,
  parameter int WIDE_ADD  = 2
) (
  input  bitop_e           op,
  input  logic             imm_form,
  input  logic             is_reg,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    cycles = imm_form ? CYC_W'(IMM_BASE) : CYC_W'(REG_BASE);
    if (op != OP_TEST) cycles = cycles + CYC_W'(MOD_EXTRA);
    if (is_reg && (op == OP_TEST || op == OP_CLR)) cycles = cycles + CYC_W'(WIDE_ADD);
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int P_DATA_W   = DATA_W,
  parameter int P_BYTE_W   = BYTE_W,
  parameter int P_BITNUM_W = BITNUM_W,
  parameter int P_CCR_W    = CCR_W,
  parameter int P_ZF_POS   = ZF_POS,
  parameter int P_CYC_W    = CYC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            in_op,
  input  logic                  in_imm_form,
  input  logic                  in_is_reg,
  input  logic [P_BITNUM_W-1:0] in_bitnum,
  input  logic [P_DATA_W-1:0]   in_operand,
  input  logic [P_CCR_W-1:0]    in_ccr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [P_DATA_W-1:0]   out_result,
  output logic                  out_wb,
  output logic [P_CCR_W-1:0]    out_ccr,
  output logic [P_CYC_W-1:0]    out_cycles
);
  localparam logic [P_CCR_W-1:0] ZF_MASK = P_CCR_W'(1) << P_ZF_POS;

  bitop_e              op;
  logic [P_DATA_W-1:0] mask, res_c;
  logic                wb_c, zero_c, fire, valid_d;
  logic [P_CCR_W-1:0]  ccr_c;
  logic [P_CYC_W-1:0]  cyc_c;

  assign op = bitop_e'(in_op);

  bitop_mask #(.DATA_W(P_DATA_W), .BYTE_W(P_BYTE_W), .BITNUM_W(P_BITNUM_W)) u_mask (
    .bitnum(in_bitnum), .is_reg(in_is_reg), .mask(mask));

  bitop_alu #(.DATA_W(P_DATA_W), .BYTE_W(P_BYTE_W)) u_alu (
    .operand(in_operand), .is_reg(in_is_reg), .op(op), .mask(mask),
    .result(res_c), .wb(wb_c), .bit_zero(zero_c));

  bitop_cycles #(.CYC_W(P_CYC_W)) u_cyc (
    .op(op), .imm_form(in_imm_form), .is_reg(in_is_reg), .cycles(cyc_c));

  // next state
  always_comb begin
    in_ready = !out_valid || out_ready;
    fire     = in_valid && in_ready;
    ccr_c    = (in_ccr & ~ZF_MASK) | (zero_c ? ZF_MASK : '0);
    if (fire)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = out_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
      out_wb     <= 1'b0;
      out_ccr    <= '0;
      out_cycles <= '0;
    end else if (fire) begin
      out_result <= res_c;
      out_wb     <= wb_c;
      out_ccr    <= ccr_c;
      out_cycles <= cyc_c;
    end
  end

  // checks
  logic [P_DATA_W-1:0] in_view;
  assign in_view = in_is_reg ? in_operand
                             : {{(P_DATA_W-P_BYTE_W){1'b0}}, in_operand[P_BYTE_W-1:0]};

  assert_flip_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && in_op == 2'b01) |-> $countones(out_result ^ $past(in_view)) == 1);
  assert_clr_no_new_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && in_op == 2'b10) |-> (out_result & ~$past(in_view)) == '0);
  assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && !in_is_reg) |-> out_result[P_DATA_W-1:P_BYTE_W] == '0);
  assert_other_flags_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire) |-> (out_ccr & ~ZF_MASK) == ($past(in_ccr) & ~ZF_MASK));
  assert_set_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire && in_op == 2'b11) |-> out_ccr[P_ZF_POS] == (out_result != $past(in_view)));
  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire) |-> out_wb == ($past(in_op) != 2'b00));
  assert_cycles_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cycles inside {5'd4, 5'd6, 5'd8, 5'd10, 5'd12, 5'd14});
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ccr)
                                 && $stable(out_wb) && $stable(out_cycles));
endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
  typedef struct {
    logic [31:0] res;
    logic        wb;
    logic [4:0]  ccr;
    logic [4:0]  cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  in_op = '0;
  logic        in_imm_form = 1'b0, in_is_reg = 1'b0;
  logic [5:0]  in_bitnum = '0;
  logic [31:0] in_operand = '0;
  logic [4:0]  in_ccr = '0;
  logic        out_valid, out_ready = 1'b0, out_wb;
  logic [31:0] out_result;
  logic [4:0]  out_ccr, out_cycles;

  int checks = 0, fails = 0, received = 0, sent = 0, stall_cnt = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  bitop_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input int op, input bit imm, input bit isr, input int bn,
                                 input logic [31:0] opnd, input logic [4:0] ccr);
    exp_t e;
    logic [31:0] v, m;
    int w;
    w = isr ? (bn % 32) : (bn % 8);
    v = isr ? opnd : (opnd & 32'hFF);
    m = 32'h1 << w;
    case (op)
      1: e.res = v ^ m;
      2: e.res = v & ~m;
      3: e.res = v | m;
      default: e.res = v;
    endcase
    e.wb  = (op != 0);
    e.ccr = (ccr & 5'b11011) | (((v & m) == 0) ? 5'b00100 : 5'b0);
    e.cyc = imm ? 5'd8 : 5'd4;
    if (op != 0) e.cyc += 5'd4;
    if (isr && (op == 0 || op == 2)) e.cyc += 5'd2;
    return e;
  endfunction

  task automatic send(input int op, input bit imm, input bit isr, input int bn,
                      input logic [31:0] opnd, input logic [4:0] ccr);
    in_valid = 1'b1; in_op = 2'(op); in_imm_form = imm; in_is_reg = isr;
    in_bitnum = 6'(bn); in_operand = opnd; in_ccr = ccr;
    while (!in_ready) @(negedge clk);
    sb.push_back(model(op, imm, isr, bn, opnd, ccr));
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer backpressure, changed just after the rising edge
  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 1;
    out_ready <= #1 ((stall_cnt % 5) != 2) && ((stall_cnt % 7) != 4);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !out_ready)
      chk(in_ready == 1'b0, "R8 in_ready low while stalled", 32'(in_ready), 32'h0);
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      if (sb.size() == 0) chk(1'b0, "R8 unexpected output", 32'h1, 32'h0);
      else begin
        e = sb.pop_front();
        received++;
        chk(out_result == e.res, "R1 R2 R3 result", out_result, e.res);
        chk(out_wb == e.wb, "R5 write-back", 32'(out_wb), 32'(e.wb));
        chk(out_ccr == e.ccr, "R4 flags", 32'(out_ccr), 32'(e.ccr));
        chk(out_cycles == e.cyc, "R6 R7 cycles", 32'(out_cycles), 32'(e.cyc));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(received), 32'(sent));
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after reset", 32'(out_valid), 32'h0);
    // directed corners: wrap at 32 and at 8
    send(3, 0, 1, 32, 32'h0000_0000, 5'b11111); // R2 bit 32 -> bit 0
    send(1, 1, 0, 15, 32'hABCD_EF00, 5'b00000); // R3 bit 15 -> bit 7, upper cleared
    send(0, 0, 0, 9, 32'hFFFF_FF02, 5'b10101);  // R3 R4 test bit 1 set
    for (int op = 0; op < 4; op++)
      for (int isr = 0; isr < 2; isr++)
        for (int imm = 0; imm < 2; imm++)
          for (int bn = 0; bn < 64; bn++) begin
            logic [31:0] pat;
            pat = (bn % 3 == 0) ? 32'hFFFF_FFFF : (bn % 3 == 1) ? 32'h0 : (32'h9E37_79B9 * (bn + 7 * op + 1));
            send(op, bit'(imm), bit'(isr), bn, pat, 5'(bn ^ (op * 3)));
          end
    while (received < sent) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R8 all results delivered", 32'(sb.size()), 32'h0);
    finish_run();
  end
endmodule